// File: doc/BRIEF.md
# Multi-Channel Divided Source Selector with Gating

This block drives a bank of output channels, each of which produces a one-cycle enable pulse at a programmed fraction of one of three source rates. The three sources arrive as clock-enable strobes inside a single system clock. Every channel holds its own source select code and a separate divide ratio for each source, so moving a channel to another source does not require reprogramming its ratio. One select code is reserved to switch the channel off.

Software programs the block through a plain word-wide write and read port. Select codes are packed two bits per channel, starting at a configurable bit. A channel whose field would go past bit 31 continues in a second select word. There is one read-only status word per source, with one bit per channel at a configurable base bit. Software writes a new select code and then polls the status word of the new source until the channel's bit reads 1. The bit only reads 1 once the new path is really producing pulses. Ratio and select changes wait for the end of the current output period, so no pulse is ever emitted early.

The register port carries single-word control accesses with no flow control. A write is accepted on every cycle in which it is asserted. A read returns its data on the cycle after it is requested.

Top module: `clkdm_bank`

## Requirements
- R1: After reset every select field holds 3, every divider value holds 0, no channel pulses and every status bit reads 0.
- R2: Select codes 0, 1 and 2 make a channel count strobes of `src_tick_i[0]`, `[1]` and `[2]` respectively. Code 3 switches the channel off: it emits no pulse and reports no running status.
- R3: With divider value D, a channel pulses on every (D+1)-th strobe of its selected source, so the ratios run from 1 to 32. The pulse is high in the cycle that follows the clock edge at which the completing strobe is sampled.
- R4: The divider value for source s of channel n is held in bits 4:0 of the word at byte address 0x100·(s+1) + 4·n. Writes keep only bits 4:0, and the upper bits read 0.
- R5: The select field of channel n sits at bit p = SEL_LSB + 2·n of the first select word (address 0x000). When p exceeds 31 it sits at bit p−32 of the second select word (address 0x004). Bits outside the channel fields are discarded on write and read 0.
- R6: The status word for source s is at address 0x010 + 4·s. Channel n reports at bit STAT_LSB + n. Writes to status words have no effect.
- R7: A status bit reads 1 only when the channel's select field equals that source, the channel is actually counting that source, and it has emitted at least one pulse from it since it last switched source. Otherwise the bit reads 0.
- R8: A new select code or divider value takes effect only at an output period boundary. A boundary is the strobe that completes a period, or any cycle in which the period counter is idle at zero. A channel switched off adopts a new code at once.
- R9: Read data is registered. It is valid in the cycle after `rd_en_i` and is held while no read is requested. Writes update the register at the clock edge that samples them.
- R10: The channel count is a parameter. Bank sizes of 4, 8 and 14 channels are supported, with SEL_LSB even and STAT_LSB + NUM_CH ≤ 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 3 | Clock-enable strobe of each of the three sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| ch_pulse_o | output | NUM_CH | One-cycle output enable pulse of each channel |

## Verification
The bench starts with a bank whose select fields spill into the second select word. A design that placed the fields by channel index alone would drive the last two channels from the wrong word. It shrinks a channel's ratio in the middle of a period. An implementation that applied the new ratio at once would emit a pulse one strobe early. It moves a channel to a new source in the middle of a period and polls the status words around the switch. A design that acknowledged the new source before it produced a pulse, or that let the old source's bit stay set, would show the wrong status word. It also writes junk to status words and to the non-field bits of the select and divider words. It switches a channel off while strobes keep arriving, which exposes any stray pulse or leftover status bit.

// File: rtl/clkdm_pkg.sv
package clkdm_pkg;
  localparam int NSRC       = 3;
  localparam int SEL_W      = 2;
  localparam int DIV_W      = 5;
  localparam int REG_W      = 32;
  localparam int WORD_BYTES = 4;

  localparam int ADDR_SEL0  = 'h000;
  localparam int ADDR_SEL1  = 'h004;
  localparam int ADDR_STAT  = 'h010;
  localparam int DIV_BASE   = 'h100;
  localparam int DIV_STRIDE = 'h100;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [DIV_W-1:0] div_t;

  localparam sel_t SEL_OFF = sel_t'(3);
endpackage

// File: rtl/clkdm_chan.sv
module clkdm_chan
  import clkdm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             tick_i,
  input  sel_t                        sel_i,
  input  logic [NSRC-1:0][DIV_W-1:0]  div_i,
  output logic                        pulse_o,
  output logic [NSRC-1:0]             run_o
);
  sel_t act_sel;
  div_t act_div;
  div_t cnt;
  logic running;
  logic src_hit;
  logic fire;
  logic load;
  div_t div_next;

  always_comb begin
    case (act_sel)
      sel_t'(0): src_hit = tick_i[0];
      sel_t'(1): src_hit = tick_i[1];
      sel_t'(2): src_hit = tick_i[2];
      default:   src_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (sel_i)
      sel_t'(0): div_next = div_i[0];
      sel_t'(1): div_next = div_i[1];
      sel_t'(2): div_next = div_i[2];
      default:   div_next = '0;
    endcase
  end

  // period ends on the completing strobe; an idle zero counter is also a boundary
  assign fire = src_hit && (cnt == act_div);
  assign load = fire || ((cnt == '0) && !src_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= SEL_OFF;
      act_div <= '0;
      cnt     <= '0;
      running <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
      if (src_hit) cnt <= fire ? '0 : cnt + DIV_W'(1);
      if (load) begin
        act_sel <= sel_i;
        act_div <= div_next;
      end
      if (load && (sel_i != act_sel)) running <= 1'b0;
      else if (fire)                  running <= 1'b1;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_run
    assign run_o[s] = running && (act_sel == sel_t'(s)) && (sel_i == sel_t'(s));
  end

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == SEL_OFF) |=> !pulse_o);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_div);

  a_r8_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && !fire) |=> ($stable(act_sel) && $stable(act_div)));
endmodule

// File: rtl/clkdm_regs.sv
module clkdm_regs
  import clkdm_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int SEL_LSB  = 8,
  parameter int STAT_LSB = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en_i,
  input  logic [ADDR_W-1:0]                      wr_addr_i,
  input  logic [REG_W-1:0]                       wr_data_i,
  input  logic                                   rd_en_i,
  input  logic [ADDR_W-1:0]                      rd_addr_i,
  output logic [REG_W-1:0]                       rd_data_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]           sel_o,
  output logic [NUM_CH-1:0][NSRC-1:0][DIV_W-1:0] div_o,
  input  logic [NUM_CH-1:0][NSRC-1:0]            run_i
);
  localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(ADDR_SEL0);
  localparam logic [ADDR_W-1:0] A_SEL1 = ADDR_W'(ADDR_SEL1);

  logic [NUM_CH-1:0][REG_W-1:0] sel_part;
  logic [NUM_CH-1:0]            sel_hi;
  logic [REG_W-1:0]             rd_next;
  logic                         unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int  POS  = SEL_LSB + SEL_W * c;
    localparam bit  HI   = (POS >= REG_W);
    localparam int  BITP = HI ? POS - REG_W : POS;
    localparam logic [ADDR_W-1:0] SEL_ADDR = HI ? A_SEL1 : A_SEL0;

    sel_t sel_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   sel_r <= SEL_OFF;
      else if (wr_en_i && (wr_addr_i == SEL_ADDR))  sel_r <= wr_data_i[BITP +: SEL_W];
    end
    assign sel_o[c]    = sel_r;
    assign sel_part[c] = REG_W'(sel_r) << BITP;
    assign sel_hi[c]   = HI;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam logic [ADDR_W-1:0] DADDR =
        ADDR_W'(DIV_BASE + DIV_STRIDE * s + WORD_BYTES * c);
      div_t div_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                div_r <= '0;
        else if (wr_en_i && (wr_addr_i == DADDR))  div_r <= wr_data_i[DIV_W-1:0];
      end
      assign div_o[c][s] = div_r;

      a_r4_div_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == DADDR)) |=> (div_o[c][s] == $past(wr_data_i[DIV_W-1:0])));
    end
  end

  always_comb begin
    rd_next = '0;
    if ((rd_addr_i == A_SEL0) || (rd_addr_i == A_SEL1)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_hi[c] == (rd_addr_i == A_SEL1)) rd_next = rd_next | sel_part[c];
      end
    end
    for (int s = 0; s < NSRC; s++) begin
      if (rd_addr_i == ADDR_W'(ADDR_STAT + WORD_BYTES * s)) begin
        for (int c = 0; c < NUM_CH; c++) begin
          rd_next = rd_next | (REG_W'(run_i[c][s]) << (STAT_LSB + c));
        end
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (rd_addr_i == ADDR_W'(DIV_BASE + DIV_STRIDE * s + WORD_BYTES * c))
          rd_next = REG_W'(div_o[c][s]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_next;
  end

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/clkdm_bank.sv
module clkdm_bank
  import clkdm_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int SEL_LSB  = 8,
  parameter int STAT_LSB = 4,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        src_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic [NUM_CH-1:0] ch_pulse_o
);
  logic [NUM_CH-1:0][SEL_W-1:0]           sel_cfg;
  logic [NUM_CH-1:0][NSRC-1:0][DIV_W-1:0] div_cfg;
  logic [NUM_CH-1:0][NSRC-1:0]            run;

  clkdm_regs #(
    .NUM_CH   (NUM_CH),
    .SEL_LSB  (SEL_LSB),
    .STAT_LSB (STAT_LSB),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .sel_o     (sel_cfg),
    .div_o     (div_cfg),
    .run_i     (run)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    clkdm_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (src_tick_i),
      .sel_i   (sel_cfg[c]),
      .div_i   (div_cfg[c]),
      .pulse_o (ch_pulse_o[c]),
      .run_o   (run[c])
    );

    // R7: a channel can be acknowledged as running on at most one source
    a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(run[c]));
  end
endmodule

// File: tb/clkdm_bank_tb_top.sv
module clkdm_bank_tb_top;
  localparam int NCH = 14;   // R10: default bank of 14 channels, fields spill to second word
  localparam int SL  = 8;
  localparam int STL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [NCH-1:0] ch_pulse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  int m_req[NCH];
  int m_act[NCH];
  int m_adiv[NCH];
  int m_cnt[NCH];
  int m_div[NCH][3];
  int exp_q[NCH][$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdm_bank #(.NUM_CH(NCH), .SEL_LSB(SL), .STAT_LSB(STL), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ch_pulse_o(ch_pulse)
  );

  // monitor: pops expected pulse cycles and compares (R2, R3, R8)
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (ch_pulse[c]) begin
        checks++;
        if (exp_q[c].size() == 0) begin
          errors++;
          $display("FAIL R2/R3 ch %0d pulse at cycle %0d, expected none", c, cyc);
        end else begin
          if (exp_q[c][0] != cyc) begin
            errors++;
            $display("FAIL R3/R8 ch %0d pulse at cycle %0d, expected %0d", c, cyc, exp_q[c][0]);
          end
          void'(exp_q[c].pop_front());
        end
      end else if (exp_q[c].size() != 0 && exp_q[c][0] <= cyc) begin
        checks++;
        errors++;
        $display("FAIL R3 ch %0d no pulse at cycle %0d, expected %0d", c, cyc, exp_q[c][0]);
        void'(exp_q[c].pop_front());
      end
    end
  end

  task automatic model_load(int c);
    m_act[c]  = m_req[c];
    m_adiv[c] = (m_req[c] == 3) ? 0 : m_div[c][m_req[c]];
  endtask

  // driver: one cycle of strobes, expected pulses pushed for the next cycle
  task automatic step(logic [2:0] t);
    src_tick = t;
    for (int c = 0; c < NCH; c++) begin
      if (m_act[c] != 3 && t[m_act[c]]) begin
        if (m_cnt[c] == m_adiv[c]) begin
          exp_q[c].push_back(cyc + 1);
          m_cnt[c] = 0;
          model_load(c);
        end else begin
          m_cnt[c]++;
        end
      end else if (m_cnt[c] == 0) begin
        model_load(c);
      end
    end
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 12'(a); wr_data = d;
    step(3'b000);
    wr_en = 1'b0;
    step(3'b000);
    step(3'b000);
  endtask

  // R9: data is sampled one cycle after the request
  task automatic rd_chk(string tag, int a, logic [31:0] exp);
    rd_en = 1'b1; rd_addr = 12'(a);
    step(3'b000);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  function automatic logic [31:0] sel_word(bit hi);
    logic [31:0] w = '0;
    for (int c = 0; c < NCH; c++) begin
      int pos = SL + 2 * c;
      if (hi && pos >= 32)       w |= 32'(m_req[c]) << (pos - 32);
      else if (!hi && pos < 32)  w |= 32'(m_req[c]) << pos;
    end
    return w;
  endfunction

  task automatic write_sels();
    wr('h000, sel_word(0));
    wr('h004, sel_word(1));
  endtask

  task automatic set_div(int c, int s, int v);
    m_div[c][s] = v;
    wr('h100 * (s + 1) + 4 * c, 32'(v));
  endtask

  task automatic drain();
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 2000; k++) begin
        bit busy = 0;
        for (int c = 0; c < NCH; c++) if (m_act[c] == s && m_cnt[c] != 0) busy = 1;
        if (!busy) break;
        step(3'(1 << s));
      end
    end
  endtask

  function automatic logic [31:0] bit_of(int c);
    return 32'(1) << (STL + c);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_req[c] = 3; m_act[c] = 3; m_adiv[c] = 0; m_cnt[c] = 0;
      for (int s = 0; s < 3; s++) m_div[c][s] = 0;
    end
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 sel word0 reset", 'h000, 32'hFFFF_FF00);
    rd_chk("R1 sel word1 reset", 'h004, 32'h0000_000F);
    rd_chk("R1 divider reset", 'h200 + 4 * 5, 32'h0);
    rd_chk("R1 status reset", 'h010, 32'h0);
    // R1/R2: all channels off, strobes must not produce pulses
    for (int i = 0; i < 20; i++) step(3'b111);

    // configure channels on different sources and ratios
    set_div(0, 0, 0);
    set_div(1, 0, 2);
    set_div(2, 1, 4);
    set_div(12, 2, 31);
    set_div(13, 1, 1);
    m_req[0] = 0; m_req[1] = 0; m_req[2] = 1; m_req[12] = 2; m_req[13] = 1;
    write_sels();
    rd_chk("R5 sel word0 readback", 'h000, sel_word(0));
    rd_chk("R5 sel word1 readback (spilled fields)", 'h004, sel_word(1));

    // R2/R3: mixed strobe pattern, each source at its own rate
    for (int i = 0; i < 200; i++) step({(i % 3) == 0, (i % 2) == 0, 1'b1});
    drain();

    // R6/R7 status after running
    rd_chk("R7 status src0", 'h010, bit_of(0) | bit_of(1));
    rd_chk("R7 status src1", 'h014, bit_of(2) | bit_of(13));
    rd_chk("R7 status src2", 'h018, bit_of(12));

    // R4 divider storage and masking
    rd_chk("R4 divider src2 ch12", 'h300 + 4 * 12, 32'd31);
    m_div[3][1] = 5;
    wr('h200 + 4 * 3, 32'hFFFF_FFE5);
    rd_chk("R4 divider upper bits dropped", 'h200 + 4 * 3, 32'd5);

    // R6 status words ignore writes
    wr('h010, 32'hFFFF_FFFF);
    rd_chk("R6 status unchanged by write", 'h010, bit_of(0) | bit_of(1));
    // R5 non-field bits dropped
    wr('h000, sel_word(0) | 32'h0000_00FF);
    rd_chk("R5 non-field bits read 0", 'h000, sel_word(0));

    // R8: ratio change mid-period waits for the boundary
    step(3'b001);
    set_div(1, 0, 0);
    for (int i = 0; i < 4; i++) step(3'b001);

    // R7/R8: source switch mid-period on ch13
    step(3'b010);
    m_req[13] = 0;
    write_sels();
    rd_chk("R7 old source bit cleared on request", 'h014, bit_of(2));
    rd_chk("R7 new source not yet acknowledged", 'h010, bit_of(0) | bit_of(1));
    step(3'b010);
    rd_chk("R7 switched but no pulse yet", 'h010, bit_of(0) | bit_of(1));
    step(3'b001);
    rd_chk("R7 new source acknowledged", 'h010, bit_of(0) | bit_of(1) | bit_of(13));

    // R2: switch-off code
    m_req[0] = 3;
    write_sels();
    for (int i = 0; i < 5; i++) step(3'b001);
    rd_chk("R2 off channel reports no status", 'h010, bit_of(1) | bit_of(13));

    for (int i = 0; i < 5; i++) step(3'b000);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (exp_q[c].size() != 0) begin
        errors++;
        $display("FAIL R3 ch %0d has %0d missing pulses, expected 0", c, exp_q[c].size());
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule